// File: doc/BRIEF.md
# Skewed-Input Systolic Matrix Multiplier

This block multiplies a P x K matrix A by a K x Q matrix B on a fixed P x Q grid of multiply-accumulate cells. The inner dimension K may be far larger than the grid. Each cell (i, j) keeps the running sum for C[i][j]. On every accepted word the host presents one column of A, which is P operands with row i in lane i, and one row of B, which is Q operands with column j in lane j. Operands of A travel rightwards along the grid rows and operands of B travel downwards along the grid columns. Every hop between cells passes through exactly one register.

Before entering the grid, A lane i is delayed by i cycles and B lane j by j cycles. Because of this skew, the two operands for step k meet in cell (i, j) on the same cycle. The array runs with a slow-down factor of two: an input slot opens only on every other cycle, and the cycles between open slots travel through the grid as bubbles.

A run starts with a start pulse, which clears every accumulator. The host then streams words, and the last word is flagged. After the last operands have crossed the far corner cell, the block signals done and presents the results one column of C per cycle.

Top module: `systolic_mm`

## Requirements
- R1: After a run of K accepted words, column j of the readout holds C[i][j] = sum over k of A[i][k]*B[k][j] in row field i (bits [i*AW +: AW] of out_col). Operands are DW-bit two's complement (default 8) and sums are AW-bit two's complement (default 24).
- R2: slot_open is high only while a run is accepting words, and never on two consecutive cycles. A run accepts at most one word per two cycles.
- R3: in_valid, in_last and the operand buses have no effect when slot_open is low. This holds both between open slots of a run and while the block is idle.
- R4: A start pulse while idle clears all accumulators and opens a run. A start pulse at any other time is ignored, so the sums already collected are kept.
- R5: done goes high exactly P+Q-1 clock edges after the edge that accepts the word flagged with in_last.
- R6: Readout lasts Q consecutive cycles with out_valid high. out_idx counts 0, 1, ..., Q-1, and done is high only in the cycle that shows column 0.
- R7: After reset, slot_open, done and out_valid are low.
- R8: Accumulation wraps modulo 2^AW. With DW=8, 1100 products of (-128)*(-128) read back as 18022400 mod 2^24.
- R9: The block returns to idle after readout. A following run with K = 1 produces the single product with no residue from the earlier run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run and clear sums (honoured only when idle) |
| in_valid | input | 1 | Operand word present (taken only when slot_open) |
| in_last | input | 1 | Marks the final word of the run |
| in_a | input | P*DW | One column of A, row i in bits [i*DW +: DW] |
| in_b | input | Q*DW | One row of B, column j in bits [j*DW +: DW] |
| slot_open | output | 1 | This cycle accepts a word |
| done | output | 1 | Sums complete, first readout column on the bus |
| out_valid | output | 1 | out_col holds a valid result column |
| out_idx | output | max(1,clog2(Q)) | Index of the column on out_col |
| out_col | output | P*AW | Column out_idx of C, row i in bits [i*AW +: AW] |

## Verification
A skew lane of the wrong depth, or a wrong hop register, pairs operands from different steps k. This shows up as wrong sums in specific rows or columns at the next readout. A phase or slot error lets closed-slot noise into the sums, or doubles words, so every entry of C is corrupted by the end of the same run. A wrong drain count moves done away from P+Q-1 edges, which the latency check detects at once. It can also expose sums that are still missing their last products. A clear that misfires, or fires late, leaves residue that the single-word run after a long run makes plain.

// File: rtl/smm_pkg.sv
package smm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DUMP  = 2'd3
  } smm_state_e;
endpackage

// File: rtl/smm_skew_lane.sv
// Fixed-depth register chain used to stagger one input lane.
module smm_skew_lane #(
  parameter int W     = 9,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign q = d;
    end else begin : g_regs
      logic [W-1:0] stage_q [DEPTH];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int s = 0; s < DEPTH; s++) stage_q[s] <= '0;
        end else begin
          stage_q[0] <= d;
          for (int s = 1; s < DEPTH; s++) stage_q[s] <= stage_q[s-1];
        end
      end
      assign q = stage_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/smm_mac_cell.sv
// One grid cell: accumulate when both operands are valid, forward both one hop.
module smm_mac_cell #(
  parameter int DW = 8,
  parameter int AW = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic [DW-1:0]        a_i,
  input  logic                 a_vi,
  input  logic [DW-1:0]        b_i,
  input  logic                 b_vi,
  output logic [DW-1:0]        a_o,
  output logic                 a_vo,
  output logic [DW-1:0]        b_o,
  output logic                 b_vo,
  output logic signed [AW-1:0] acc_o
);
  logic signed [2*DW-1:0] prod;
  logic signed [AW-1:0]   acc_n;

  always_comb begin
    prod  = $signed(a_i) * $signed(b_i);
    acc_n = acc_o;
    if (clr)                acc_n = '0;
    else if (a_vi && b_vi)  acc_n = acc_o + AW'(prod);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_o <= '0;
      a_o   <= '0;
      a_vo  <= 1'b0;
      b_o   <= '0;
      b_vo  <= 1'b0;
    end else begin
      acc_o <= acc_n;
      a_o   <= a_i;
      a_vo  <= a_vi;
      b_o   <= b_i;
      b_vo  <= b_vi;
    end
  end
endmodule

// File: rtl/systolic_mm.sv
module systolic_mm
  import smm_pkg::*;
#(
  parameter int P  = 4,
  parameter int Q  = 3,
  parameter int DW = 8,
  parameter int AW = 24,
  localparam int IDX_W = (Q > 1) ? $clog2(Q) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            in_valid,
  input  logic            in_last,
  input  logic [P*DW-1:0] in_a,
  input  logic [Q*DW-1:0] in_b,
  output logic            slot_open,
  output logic            done,
  output logic            out_valid,
  output logic [IDX_W-1:0] out_idx,
  output logic [P*AW-1:0] out_col
);
  localparam int DRAIN_LAST = P + Q - 2;
  localparam int CNT_W      = $clog2(P + Q);

  smm_state_e       state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [IDX_W-1:0] col_q, col_n;
  logic             phase_q;
  logic             accept, clr;

  // Control: next state
  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    col_n   = col_q;
    clr     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_n = ST_RUN;
        clr     = 1'b1;
      end
      ST_RUN: if (accept && in_last) begin
        state_n = ST_DRAIN;
        cnt_n   = '0;
      end
      ST_DRAIN: begin
        if (cnt_q == CNT_W'(DRAIN_LAST)) begin
          state_n = ST_DUMP;
          col_n   = '0;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      ST_DUMP: begin
        if (col_q == IDX_W'(Q - 1)) state_n = ST_IDLE;
        else                        col_n   = col_q + 1'b1;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  // Control: registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      col_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      col_q   <= col_n;
      phase_q <= ~phase_q;
    end
  end

  assign slot_open = (state_q == ST_RUN) && !phase_q;
  assign accept    = slot_open && in_valid;

  // Skewed edge lanes: bubbles carry zero data and a low valid bit
  logic [DW-1:0] a_w  [P][Q];
  logic          av_w [P][Q];
  logic [DW-1:0] b_w  [P][Q];
  logic          bv_w [P][Q];
  logic signed [AW-1:0] acc_w [P][Q];
  logic [DW:0]   a_lane [P];
  logic [DW:0]   b_lane [Q];

  generate
    for (genvar i = 0; i < P; i++) begin : g_row_skew
      smm_skew_lane #(.W(DW + 1), .DEPTH(i)) u_skew (
        .clk(clk), .rst_n(rst_n),
        .d({accept, accept ? in_a[i*DW +: DW] : {DW{1'b0}}}),
        .q(a_lane[i])
      );
    end
    for (genvar j = 0; j < Q; j++) begin : g_col_skew
      smm_skew_lane #(.W(DW + 1), .DEPTH(j)) u_skew (
        .clk(clk), .rst_n(rst_n),
        .d({accept, accept ? in_b[j*DW +: DW] : {DW{1'b0}}}),
        .q(b_lane[j])
      );
    end

    for (genvar i = 0; i < P; i++) begin : g_r
      for (genvar j = 0; j < Q; j++) begin : g_c
        logic [DW-1:0] a_in, b_in;
        logic          av_in, bv_in;
        if (j == 0) begin : g_aedge
          assign a_in  = a_lane[i][DW-1:0];
          assign av_in = a_lane[i][DW];
        end else begin : g_ahop
          assign a_in  = a_w[i][j-1];
          assign av_in = av_w[i][j-1];
        end
        if (i == 0) begin : g_bedge
          assign b_in  = b_lane[j][DW-1:0];
          assign bv_in = b_lane[j][DW];
        end else begin : g_bhop
          assign b_in  = b_w[i-1][j];
          assign bv_in = bv_w[i-1][j];
        end
        smm_mac_cell #(.DW(DW), .AW(AW)) u_cell (
          .clk(clk), .rst_n(rst_n), .clr(clr),
          .a_i(a_in), .a_vi(av_in), .b_i(b_in), .b_vi(bv_in),
          .a_o(a_w[i][j]), .a_vo(av_w[i][j]),
          .b_o(b_w[i][j]), .b_vo(bv_w[i][j]),
          .acc_o(acc_w[i][j])
        );
      end
    end

    for (genvar i = 0; i < P; i++) begin : g_out
      assign out_col[i*AW +: AW] = acc_w[i][col_q];
    end
  endgenerate

  assign out_valid = (state_q == ST_DUMP);
  assign out_idx   = col_q;
  assign done      = out_valid && (col_q == '0);
endmodule

// File: rtl/smm_checker.sv
module smm_checker #(
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             slot_open,
  input logic             done,
  input logic             out_valid,
  input logic [IDX_W-1:0] out_idx
);
  assert_slot_alternate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_open |=> !slot_open);

  assert_no_slot_in_dump_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_open && out_valid));

  assert_done_first_col_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (out_valid && out_idx == '0));

  assert_dump_starts_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> done);

  assert_idx_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> (out_idx == $past(out_idx) + 1'b1));
endmodule

bind systolic_mm smm_checker #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_open(slot_open), .done(done),
  .out_valid(out_valid), .out_idx(out_idx)
);

// File: tb/sim_systolic_mm.sv
`timescale 1ns/1ps
module sim_systolic_mm;
  localparam int P = 4, Q = 3, DW = 8, AW = 24;
  localparam int IDX_W = 2;
  localparam int KMAX = 1100;

  logic clk, rst_n, start, in_valid, in_last;
  logic [P*DW-1:0] in_a;
  logic [Q*DW-1:0] in_b;
  logic slot_open, done, out_valid;
  logic [IDX_W-1:0] out_idx;
  logic [P*AW-1:0] out_col;

  systolic_mm #(.P(P), .Q(Q), .DW(DW), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_last(in_last), .in_a(in_a), .in_b(in_b), .slot_open(slot_open),
    .done(done), .out_valid(out_valid), .out_idx(out_idx), .out_col(out_col)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic signed [DW-1:0] ma [P][KMAX];
  logic signed [DW-1:0] mb [KMAX][Q];
  logic signed [AW-1:0] expc [P][Q];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  task automatic calc_expected(input int k);
    for (int i = 0; i < P; i++)
      for (int j = 0; j < Q; j++) begin
        logic signed [AW-1:0] s;
        s = '0;
        for (int t = 0; t < k; t++) s = s + AW'(ma[i][t] * mb[t][j]);
        expc[i][j] = s;
      end
  endtask

  // Runs one job: start, stream k words, check latency, readout and sums.
  task automatic run_job(input int k, input bit noise, input bit mid_start, input string req);
    int t, lat;
    calc_expected(k);
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    t = 0;
    while (t < k) begin
      @(negedge clk);
      start = 1'b0;
      if (slot_open) begin
        in_valid = 1'b1;
        in_last  = (t == k - 1);
        for (int i = 0; i < P; i++) in_a[i*DW +: DW] = ma[i][t];
        for (int j = 0; j < Q; j++) in_b[j*DW +: DW] = mb[t][j];
        if (mid_start && t == 1) start = 1'b1;  // R4: must be ignored
        t++;
      end else if (noise) begin
        in_valid = 1'b1;                        // R3: closed slot, ignored
        in_last  = 1'b1;
        in_a = {$urandom, $urandom};
        in_b = {$urandom};
      end else begin
        in_valid = 1'b0;
        in_last  = 1'b0;
      end
      @(posedge clk);
    end
    lat = 0;
    forever begin
      @(negedge clk);
      start = 1'b0; in_valid = 1'b0; in_last = 1'b0;
      if (done || lat > 50) break;
      @(posedge clk);
      lat++;
    end
    check(lat == P + Q - 1, "R5 done latency", lat, P + Q - 1);
    for (int c = 0; c < Q; c++) begin
      if (c > 0) @(negedge clk);
      check(out_valid == 1'b1, "R6 out_valid", out_valid, 1);
      check(out_idx == IDX_W'(c), "R6 out_idx", out_idx, c);
      check(done == (c == 0), "R6 done only on column 0", done, (c == 0));
      for (int i = 0; i < P; i++) begin
        logic signed [AW-1:0] got;
        got = out_col[i*AW +: AW];
        check(got == expc[i][c], req, got, expc[i][c]);
      end
    end
    @(negedge clk);
    check(out_valid == 1'b0, "R9 back to idle", out_valid, 0);
  endtask

  task automatic fill_random(input int k);
    for (int t = 0; t < k; t++) begin
      for (int i = 0; i < P; i++) ma[i][t] = DW'($urandom_range(0, 255));
      for (int j = 0; j < Q; j++) mb[t][j] = DW'($urandom_range(0, 255));
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(slot_open == 1'b0, "R7 slot_open", slot_open, 0);
    check(done == 1'b0, "R7 done", done, 0);
    check(out_valid == 1'b0, "R7 out_valid", out_valid, 0);
  endtask

  task automatic t_idle_noise();
    // R3: traffic while idle is ignored and opens no slot
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      in_valid = 1'b1; in_last = 1'b1; in_a = {$urandom, $urandom}; in_b = {$urandom};
      check(slot_open == 1'b0, "R3 no slot when idle", slot_open, 0);
      check(out_valid == 1'b0, "R3 no output when idle", out_valid, 0);
    end
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic t_random_noise();
    fill_random(9);
    run_job(9, 1'b1, 1'b0, "R1 R3 random with closed-slot noise");
  endtask

  task automatic t_mid_start();
    fill_random(6);
    run_job(6, 1'b0, 1'b1, "R4 start during run ignored");
  endtask

  task automatic t_wrap();
    for (int t = 0; t < KMAX; t++) begin
      for (int i = 0; i < P; i++) ma[i][t] = -8'sd128;
      for (int j = 0; j < Q; j++) mb[t][j] = -8'sd128;
    end
    run_job(KMAX, 1'b0, 1'b0, "R8 modular wrap");
    check(expc[0][0] == AW'(18022400), "R8 reference value", expc[0][0], 18022400 % 16777216);
  endtask

  task automatic t_single();
    fill_random(1);
    run_job(1, 1'b1, 1'b0, "R9 single word after long run (R4 clear)");
  endtask

  task automatic t_signs();
    for (int t = 0; t < 4; t++) begin
      for (int i = 0; i < P; i++) ma[i][t] = (i % 2 == 0) ? 8'sd127 : -8'sd128;
      for (int j = 0; j < Q; j++) mb[t][j] = DW'(j - 1);
    end
    run_job(4, 1'b0, 1'b0, "R1 signed extremes");
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; in_valid = 1'b0; in_last = 1'b0;
    in_a = '0; in_b = '0;
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_idle_noise();
    t_random_noise();
    t_mid_start();
    t_signs();
    t_wrap();
    t_single();
    finish_run();
  end
endmodule